// File: doc/BRIEF.md
# Flash Block Lock Register File

This block sits between a flash bus decoder and the flash array. It keeps one small lock register for each 64 KB block of a 512 KB array. Each register carries a write-lock bit and a read-lock bit. It also keeps a sticky boot-block lockout flag and offers a pass-through view of five general-purpose input pins. The decoder reaches all of this through a plain register port: a write strobe with an address and data, and a combinational read-back bus.

Program and erase requests come in on a valid/ready stream and go out to the array on a second valid/ready stream. A request that targets a write-locked block, or the boot block once the lockout is set, is not forwarded. It is accepted at once so that it cannot stall the source, and a one-cycle reject pulse follows. Chip erase is always forwarded, and it carries a flag that tells the array to leave the boot block intact.

Read data coming back from the array passes through a second valid/ready stream. The data is forced to zero when the addressed block is read-locked. Both streams are combinational. Back-pressure from the sink reaches the source in the same cycle, except that a dropped request is accepted no matter what the sink's ready is. The source may change its request in any cycle; the block holds no stream state.

Top module: `flash_lock_regs`

## Requirements
- R1: After reset, every lock register reads 00h, the boot lockout flag reads 0, no request is dropped and no read data is masked.
- R2: Register addresses 0 to 7 are the lock registers of blocks 0 to 7. Bit 0 is the write lock and bit 1 is the read lock, and the other bits read as 0. A write takes effect from the next clock edge, and either bit may be set or cleared at any time.
- R3: On the read stream, the block index is address bits [18:16]. When the addressed block's read lock is set, rd_out_data is 00h; otherwise it equals rd_in_data.
- R4: A program request (op 00b) or block-erase request (op 01b) whose block (req_addr[18:16]) is write-locked is not forwarded (arr_valid 0), and req_ready is 1 in that cycle.
- R5: Each dropped request raises req_reject for exactly the one cycle that follows it. req_reject is 0 after every cycle with no dropped request.
- R6: Writing register address 9 with bit 0 set turns on the boot lockout. From then on, program and block-erase requests to the boot block (block 7) are dropped whatever its write lock holds, and the other blocks are unaffected.
- R7: The boot lockout flag reads back at bit 0 of address 9. Writes with bit 0 clear leave it unchanged, and only reset clears it.
- R8: Chip erase (op 1xb) is always forwarded, with arr_keep_boot equal to the boot lockout flag.
- R9: Register address 8 returns the live state of the five gpi_pins in bits [4:0] in the same cycle, with bits [7:5] read as 0. Writes to it have no effect.
- R10: A forwarded request gives arr_valid = req_valid and req_ready = arr_ready, with op and address passed unchanged. The read stream gives rd_out_valid = rd_in_valid and rd_in_ready = rd_out_ready.
- R11: Register addresses 10 to 15 read as 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| gpi_pins | input | 5 | General-purpose input pins |
| req_valid | input | 1 | Program/erase request valid |
| req_ready | output | 1 | Request accepted |
| req_op | input | 2 | 00 program, 01 block erase, 1x chip erase |
| req_addr | input | 19 | Array byte address of the request |
| arr_valid | output | 1 | Forwarded request valid |
| arr_ready | input | 1 | Array accepts a request |
| arr_op | output | 2 | Forwarded operation |
| arr_addr | output | 19 | Forwarded address |
| arr_keep_boot | output | 1 | Chip erase must keep the boot block |
| req_reject | output | 1 | One-cycle pulse after a dropped request |
| rd_in_valid | input | 1 | Array read data valid |
| rd_in_ready | output | 1 | Read data accepted |
| rd_in_addr | input | 19 | Address of the read data |
| rd_in_data | input | 8 | Read data from the array |
| rd_out_valid | output | 1 | Masked read data valid |
| rd_out_ready | input | 1 | Read sink ready |
| rd_out_data | output | 8 | Read data after masking |

## Verification
The stream outputs, the masked read data and the register read-back are all combinational, so their results are due in the cycle of the stimulus. The bench drives inputs at the falling edge and compares 1 ns later. A register write counts from the rising edge that captures it, and the bench writes at the falling edge and checks only from the next cycle on. req_reject is due one cycle after the dropped request: the bench samples it 1 ns after the following rising edge, then drops req_valid before the next edge so that no extra pulse is produced.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int WL_BIT = 0;
  localparam int RL_BIT = 1;
  localparam int BOOT_BIT = 0;

  typedef struct packed {
    logic rlock;
    logic wlock;
  } lock_t;

  function automatic logic op_is_chip(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/lock_bank.sv
module lock_bank
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int DW = 8,
  parameter int REG_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  output logic [NUM_BLK-1:0] wlock,
  output logic [NUM_BLK-1:0] rlock,
  output logic               boot_lock
);
  localparam int BOOT_ADDR = NUM_BLK + 1;

  lock_t regs [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr && addr == REG_AW'(g)) begin
        regs[g].wlock <= wdata[WL_BIT];
        regs[g].rlock <= wdata[RL_BIT];
      end
    end
    assign wlock[g] = regs[g].wlock;
    assign rlock[g] = regs[g].rlock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_lock <= 1'b0;
    else if (wr && addr == REG_AW'(BOOT_ADDR) && wdata[BOOT_BIT]) boot_lock <= 1'b1;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_lock |=> boot_lock); // R7
endmodule

// File: rtl/req_gate.sv
module req_gate
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int ADDR_W = 19,
  parameter int BOOT_BLK = NUM_BLK - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               arr_valid,
  input  logic               arr_ready,
  output logic [1:0]         arr_op,
  output logic [ADDR_W-1:0]  arr_addr,
  output logic               arr_keep_boot,
  output logic               reject,
  input  logic [NUM_BLK-1:0] wlock,
  input  logic               boot_lock
);
  localparam int IDX_W = $clog2(NUM_BLK);

  logic [IDX_W-1:0] blk;
  logic             targeted;
  logic             blocked;

  assign blk      = req_addr[ADDR_W-1 -: IDX_W];
  assign targeted = !op_is_chip(req_op);
  assign blocked  = targeted &&
                    (wlock[blk] || (boot_lock && blk == IDX_W'(BOOT_BLK)));

  assign arr_valid     = req_valid && !blocked;
  assign req_ready     = blocked ? 1'b1 : arr_ready;
  assign arr_op        = req_op;
  assign arr_addr      = req_addr;
  assign arr_keep_boot = boot_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject <= 1'b0;
    else        reject <= req_valid && blocked;
  end

  AST_LOCKED_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !op_is_chip(arr_op)) |-> !wlock[arr_addr[ADDR_W-1 -: IDX_W]]); // R4
  AST_BOOT_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && boot_lock && !op_is_chip(arr_op)) |->
      arr_addr[ADDR_W-1 -: IDX_W] != IDX_W'(BOOT_BLK)); // R6
  AST_REJECT_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(req_valid && !arr_valid)); // R5
  AST_CHIP_ALWAYS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_is_chip(req_op)) |-> arr_valid); // R8
endmodule

// File: rtl/read_mask.sv
module read_mask #(
  parameter int NUM_BLK = 8,
  parameter int ADDR_W = 19,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_in_valid,
  output logic               rd_in_ready,
  input  logic [ADDR_W-1:0]  rd_in_addr,
  input  logic [DW-1:0]      rd_in_data,
  output logic               rd_out_valid,
  input  logic               rd_out_ready,
  output logic [DW-1:0]      rd_out_data,
  input  logic [NUM_BLK-1:0] rlock
);
  localparam int IDX_W = $clog2(NUM_BLK);

  logic [IDX_W-1:0] blk;
  assign blk = rd_in_addr[ADDR_W-1 -: IDX_W];

  assign rd_out_valid = rd_in_valid;
  assign rd_in_ready  = rd_out_ready;
  assign rd_out_data  = rlock[blk] ? '0 : rd_in_data;

  logic unused_addr;
  assign unused_addr = ^rd_in_addr;

  AST_RLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rlock[blk]) |-> rd_out_data == '0); // R3
  AST_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !rlock[blk]) |-> rd_out_data == rd_in_data); // R3
endmodule

// File: rtl/flash_lock_regs.sv
module flash_lock_regs
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_AW = 16,
  parameter int DW = 8,
  parameter int GPI_W = 5,
  parameter int REG_AW = 4,
  parameter int BOOT_BLK = NUM_BLK - 1,
  localparam int ADDR_W = $clog2(NUM_BLK) + BLK_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [GPI_W-1:0]  gpi_pins,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_keep_boot,
  output logic              req_reject,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [ADDR_W-1:0] rd_in_addr,
  input  logic [DW-1:0]     rd_in_data,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DW-1:0]     rd_out_data
);
  localparam int GPI_ADDR  = NUM_BLK;
  localparam int BOOT_ADDR = NUM_BLK + 1;

  logic [NUM_BLK-1:0] wlock;
  logic [NUM_BLK-1:0] rlock;
  logic               boot_lock;

  lock_bank #(.NUM_BLK(NUM_BLK), .DW(DW), .REG_AW(REG_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .wlock(wlock), .rlock(rlock), .boot_lock(boot_lock)
  );

  req_gate #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .BOOT_BLK(BOOT_BLK)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .arr_valid(arr_valid),
    .arr_ready(arr_ready), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_keep_boot(arr_keep_boot), .reject(req_reject), .wlock(wlock),
    .boot_lock(boot_lock)
  );

  read_mask #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DW(DW)) u_mask (
    .clk(clk), .rst_n(rst_n), .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
    .rd_in_addr(rd_in_addr), .rd_in_data(rd_in_data), .rd_out_valid(rd_out_valid),
    .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data), .rlock(rlock)
  );

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) < NUM_BLK) begin
      reg_rdata[WL_BIT] = wlock[reg_addr[$clog2(NUM_BLK)-1:0]];
      reg_rdata[RL_BIT] = rlock[reg_addr[$clog2(NUM_BLK)-1:0]];
    end else if (reg_addr == REG_AW'(GPI_ADDR)) begin
      reg_rdata[GPI_W-1:0] = gpi_pins;
    end else if (reg_addr == REG_AW'(BOOT_ADDR)) begin
      reg_rdata[BOOT_BIT] = boot_lock;
    end
  end

  AST_GPI_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_AW'(GPI_ADDR)) |->
      (reg_rdata[GPI_W-1:0] == gpi_pins && reg_rdata[DW-1:GPI_W] == '0)); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) > BOOT_ADDR) |-> reg_rdata == '0); // R11
  AST_REQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> (req_ready == arr_ready && arr_op == req_op && arr_addr == req_addr)); // R10
endmodule

// File: tb/flash_lock_regs_test.sv
module flash_lock_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] gpi_pins = 5'h0A;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [18:0] req_addr = '0;
  logic arr_valid, arr_ready = 1'b1;
  logic [1:0] arr_op;
  logic [18:0] arr_addr;
  logic arr_keep_boot, req_reject;
  logic rd_in_valid = 1'b0, rd_in_ready;
  logic [18:0] rd_in_addr = '0;
  logic [7:0] rd_in_data = '0;
  logic rd_out_valid, rd_out_ready = 1'b1;
  logic [7:0] rd_out_data;

  flash_lock_regs uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic m_wl [8];
  logic m_rl [8];
  logic m_boot;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int a);
    if (a < 8) return {6'b0, m_rl[a], m_wl[a]};
    if (a == 8) return {3'b0, gpi_pins};
    if (a == 9) return {7'b0, m_boot};
    return 8'h00;
  endfunction

  function automatic bit exp_allowed(input logic [1:0] op, input int b);
    if (op[1]) return 1'b1;
    return !(m_wl[b] || (m_boot && b == 7));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_wl[i] = 0; m_rl[i] = 0; end
    m_boot = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; req_valid = 0; rd_in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic reg_write(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    if (a < 8) begin m_wl[a] = d[0]; m_rl[a] = d[1]; end
    else if (a == 9 && d[0]) m_boot = 1;
  endtask

  task automatic reg_check(input int a, input string tag);
    @(negedge clk);
    reg_wr = 0; reg_addr = 4'(a); #1;
    chk(reg_rdata == exp_reg(a), tag, reg_rdata, exp_reg(a));
  endtask

  task automatic req_check(input logic [1:0] op, input logic [18:0] ad, input logic rdy);
    bit al;
    al = exp_allowed(op, int'(ad[18:16]));
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = ad; arr_ready = rdy; #1;
    chk(arr_valid == al, al ? "R10 fwd valid" : "R4 drop valid", arr_valid, al);
    chk(req_ready == (al ? rdy : 1'b1), "R4 ready", req_ready, al ? rdy : 1'b1);
    if (al) chk(arr_addr == ad && arr_op == op, "R10 pass", arr_addr, ad);
    if (op[1]) chk(arr_keep_boot == m_boot, "R8 keep boot", arr_keep_boot, m_boot);
    @(posedge clk); #1;
    chk(req_reject == !al, "R5 reject", req_reject, !al);
    req_valid = 0;
  endtask

  task automatic idle_reject_check();
    @(posedge clk); #1;
    chk(req_reject == 1'b0, "R5 no reject", req_reject, 0);
  endtask

  task automatic rd_check(input logic [18:0] ad, input logic [7:0] d, input logic rdy);
    logic [7:0] e;
    e = m_rl[ad[18:16]] ? 8'h00 : d;
    @(negedge clk);
    rd_in_valid = 1; rd_in_addr = ad; rd_in_data = d; rd_out_ready = rdy; #1;
    chk(rd_out_data == e, "R3 masked data", rd_out_data, e);
    chk(rd_out_valid == 1'b1 && rd_in_ready == rdy, "R10 read stream", rd_in_ready, rdy);
    rd_in_valid = 0;
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      k = $urandom_range(0, 4);
      case (k)
        0: reg_write($urandom_range(0, 15), 8'($urandom()));
        1: reg_check($urandom_range(0, 15), "R2 R11 random read");
        2: req_check(2'($urandom()), 19'($urandom()), 1'($urandom()));
        3: rd_check(19'($urandom()), 8'($urandom()), 1'($urandom()));
        default: begin gpi_pins = 5'($urandom()); reg_check(8, "R9 random gpi"); end
      endcase
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    do_reset();
    // R1 reset state
    for (int a = 0; a < 10; a++) reg_check(a, "R1 reset regs");
    req_check(2'b00, 19'h7_1234, 1);
    rd_check(19'h3_0000, 8'hA5, 1);
    // R2 set and clear
    reg_write(3, 8'hFF);
    reg_check(3, "R2 set both bits");
    req_check(2'b01, 19'h3_FFFF, 1);
    req_check(2'b00, 19'h2_FFFF, 0);
    rd_check(19'h3_0010, 8'h5A, 1);
    reg_write(3, 8'h02);
    reg_check(3, "R2 clear write lock");
    req_check(2'b00, 19'h3_0000, 1);
    rd_check(19'h3_0000, 8'h5A, 0);
    // R5 two drops in a row, then idle
    reg_write(0, 8'h01);
    req_check(2'b00, 19'h0_0001, 1);
    req_check(2'b01, 19'h0_8000, 1);
    idle_reject_check();
    // R11 spare writes ignored
    reg_write(12, 8'hFF);
    reg_write(8, 8'hFF);
    for (int a = 0; a < 16; a++) reg_check(a, "R11 after spare write");
    // R9 live gpi
    gpi_pins = 5'h1F; reg_check(8, "R9 gpi all ones");
    gpi_pins = 5'h00; reg_check(8, "R9 gpi zero");
    // R8 chip erase before lockout
    req_check(2'b10, 19'h0_0000, 1);
    // R6 boot lockout
    req_check(2'b00, 19'h7_0000, 1);
    reg_write(9, 8'h01);
    reg_check(9, "R7 boot readback");
    req_check(2'b00, 19'h7_0000, 1);
    req_check(2'b01, 19'h7_FFFF, 1);
    req_check(2'b00, 19'h6_FFFF, 1);
    req_check(2'b11, 19'h7_0000, 1);
    // R7 clear attempt ignored
    reg_write(9, 8'hFE);
    reg_check(9, "R7 boot sticky");
    req_check(2'b01, 19'h7_0100, 1);
    random_phase(600);
    do_reset();
    reg_check(9, "R7 boot cleared by reset");
    req_check(2'b00, 19'h7_0000, 1);
    random_phase(600);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule